// File: doc/BRIEF.md
# Two-Rank Crosspoint Configuration Register

This block is the configuration store for a switch matrix with 33 inputs and 17 outputs. A host reaches it over a parallel port with active-low strobes. The port has a 5-bit output address and a 7-bit data word. Bits [5:0] of the word are an input number and bit 6 is an output enable. The bidirectional data bus is split into a data-in port, a data-out port and a drive-enable. All strobes are sampled on the rising edge of the system clock.

Each output has two entries. The staged entry is what the host writes. The live entry is what the matrix uses. A global update copies every staged entry into the live rank in a single clock edge, so all connections change together. If the host writes while update is low, the written word also goes straight into the live rank of the addressed output (write-through). Writing to the broadcast address programs all 17 outputs at once. Readback always returns the live rank.

The live selections and enables for all outputs leave the block as flat vectors that feed the matrix multiplexers.

Top module: `xpt_cfg_top`

## Requirements
- R1: While `rst_n` is low, every live enable, every live selection and every staged entry is 0. As a result, an update issued just after reset leaves all outputs disabled and on input 0.
- R2: While `cs_n` is high, writes, updates and reads have no effect: the live outputs keep their values, `dout_oe` is 0 and `dout` is 0.
- R3: With `cs_n` low, `we_n` low and `upd_n` high, `din` is stored in the staged entry of output `addr` (0..16), and no live entry changes.
- R4: With `cs_n` low and `re_n` low, `dout_oe` is 1 and `dout` shows the live entry of output `addr`: enable on bit 6, selection on bits [5:0].
- R5: With `cs_n` low, `upd_n` low and `we_n` high, all 17 staged entries are copied into the live rank on the same clock edge.
- R6: With `cs_n`, `we_n` and `upd_n` all low, `din` is written into both the staged and the live entry of the addressed output, and every other output's live entry takes its staged entry.
- R7: A write to address 17 stores `din` into the entries of all 17 outputs.
- R8: A read at address 17 or above returns all zeros on `dout`, with `dout_oe` at 1.
- R9: A write to address 18..31 changes no entry.
- R10: A write of an input number of 33 or more, to address 0..17, is stored as given, and `sel_err` is 1 during that cycle. Otherwise `sel_err` is 0.
- R11: When a read and a write happen in the same cycle, the write takes effect and `dout` shows the live value from before that write.
- R12: Output i's live selection is on `live_sel[6*i+5:6*i]` and its live enable is on `live_en[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| re_n | input | 1 | Active-low read strobe |
| upd_n | input | 1 | Active-low global update |
| addr | input | 5 | Output address; 17 is broadcast |
| din | input | 7 | Write data: bit 6 enable, bits [5:0] input number |
| dout | output | 7 | Readback of the live entry |
| dout_oe | output | 1 | Drive enable for the data bus |
| live_sel | output | 102 | Live input selection, 6 bits per output |
| live_en | output | 17 | Live enable, one bit per output |
| sel_err | output | 1 | An accepted write carries an input number above 32 |

## Verification
The bench goes after the cases where the two ranks can drift apart. A staged write with no update must leave the live outputs alone; a design that wrote through would move the matrix early. In write-through mode the non-addressed outputs must pick up their staged entries; a design that updated only the addressed output would leave stale connections. The broadcast and reserved addresses are exercised for both write and read, which catches decoders that alias address 17 or 20 onto a real output. A read in the same cycle as a write or write-through must return the old live value, which exposes a readback path taken from the staged rank or from the incoming data.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;

  // True when an address names a real output.
  function automatic logic is_out_addr(input int unsigned a, input int unsigned n_out);
    return a < n_out;
  endfunction

  // The broadcast code sits one past the last output.
  function automatic logic is_bcast_addr(input int unsigned a, input int unsigned n_out);
    return a == n_out;
  endfunction

  // An input number at or above the input count is reserved.
  function automatic logic is_sel_reserved(input int unsigned s, input int unsigned n_in);
    return s >= n_in;
  endfunction

endpackage

// File: rtl/xpt_host_dec.sv
module xpt_host_dec #(
  parameter int N_OUT  = 17,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              re_n,
  input  logic              upd_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_OUT-1:0]  wr_hit,
  output logic              wr_go,
  output logic              upd_go,
  output logic              rd_go,
  output logic              addr_is_out
);
  import xpt_cfg_pkg::*;

  logic active;
  logic bcast;

  assign active      = !cs_n;
  assign addr_is_out = is_out_addr(int'(addr), N_OUT);
  assign bcast       = is_bcast_addr(int'(addr), N_OUT);
  assign wr_go       = active && !we_n && (addr_is_out || bcast);
  assign upd_go      = active && !upd_n;
  assign rd_go       = active && !re_n;

  for (genvar i = 0; i < N_OUT; i++) begin : g_hit
    assign wr_hit[i] = wr_go && (bcast || (addr == ADDR_W'(i)));
  end

  // R2
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (wr_hit == '0) && !upd_go && !rd_go);

  // R7
  bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n && addr == ADDR_W'(N_OUT)) |-> (&wr_hit));

  // R9
  rsvd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > ADDR_W'(N_OUT)) |-> (wr_hit == '0));

  // R3
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < ADDR_W'(N_OUT)) |-> $onehot0(wr_hit));

endmodule

// File: rtl/xpt_rank_cell.sv
module xpt_rank_cell #(
  parameter int ENTRY_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic               upd_go,
  input  logic [ENTRY_W-1:0] wdata,
  output logic [ENTRY_W-1:0] stage_q,
  output logic [ENTRY_W-1:0] live_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
    end else begin
      if (wr_hit) stage_q <= wdata;
      if (upd_go) live_q  <= wr_hit ? wdata : stage_q;
    end
  end

  // R3
  stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !upd_go) |=> (stage_q == $past(wdata)) && $stable(live_q));

  // R5
  global_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && !wr_hit) |=> (live_q == $past(stage_q)) && $stable(stage_q));

  // R6
  write_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && wr_hit) |=> (live_q == $past(wdata)) && (stage_q == $past(wdata)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_go && !wr_hit) |=> $stable(live_q) && $stable(stage_q));

endmodule

// File: rtl/xpt_readback.sv
module xpt_readback #(
  parameter int N_OUT   = 17,
  parameter int ENTRY_W = 7,
  parameter int ADDR_W  = 5
) (
  input  logic [ENTRY_W-1:0] live [N_OUT],
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd_go,
  input  logic               addr_is_out,
  output logic [ENTRY_W-1:0] dout,
  output logic               dout_oe
);

  always_comb begin
    dout = '0;
    if (rd_go && addr_is_out) begin
      for (int i = 0; i < N_OUT; i++) begin
        if (addr == ADDR_W'(i)) dout = live[i];
      end
    end
  end

  assign dout_oe = rd_go;

endmodule

// File: rtl/xpt_cfg_top.sv
module xpt_cfg_top #(
  parameter int N_OUT  = 17,
  parameter int N_IN   = 33,
  parameter int SEL_W  = 6,
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   we_n,
  input  logic                   re_n,
  input  logic                   upd_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [SEL_W:0]         din,
  output logic [SEL_W:0]         dout,
  output logic                   dout_oe,
  output logic [N_OUT*SEL_W-1:0] live_sel,
  output logic [N_OUT-1:0]       live_en,
  output logic                   sel_err
);
  import xpt_cfg_pkg::*;

  localparam int ENTRY_W = SEL_W + 1;

  logic [N_OUT-1:0]   wr_hit;
  logic               wr_go;
  logic               upd_go;
  logic               rd_go;
  logic               addr_is_out;
  logic [ENTRY_W-1:0] stage_q [N_OUT];
  logic [ENTRY_W-1:0] live_q  [N_OUT];

  xpt_host_dec #(.N_OUT(N_OUT), .ADDR_W(ADDR_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .re_n(re_n),
    .upd_n(upd_n), .addr(addr), .wr_hit(wr_hit), .wr_go(wr_go),
    .upd_go(upd_go), .rd_go(rd_go), .addr_is_out(addr_is_out)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    xpt_rank_cell #(.ENTRY_W(ENTRY_W)) cell_i (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit[i]), .upd_go(upd_go),
      .wdata(din), .stage_q(stage_q[i]), .live_q(live_q[i])
    );
    assign live_sel[i*SEL_W +: SEL_W] = live_q[i][SEL_W-1:0];
    assign live_en[i]                 = live_q[i][SEL_W];
  end

  xpt_readback #(.N_OUT(N_OUT), .ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W)) rb_i (
    .live(live_q), .addr(addr), .rd_go(rd_go), .addr_is_out(addr_is_out),
    .dout(dout), .dout_oe(dout_oe)
  );

  assign sel_err = wr_go && is_sel_reserved(int'(din[SEL_W-1:0]), N_IN);

  // R10
  sel_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> (!cs_n && !we_n && (wr_hit != '0)));

  // R4
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !re_n) |-> dout_oe);

  // R8
  rd_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !re_n && addr >= ADDR_W'(N_OUT)) |-> (dout == '0));

  // R1
  post_reset_chk: assert property (@(posedge clk)
    !rst_n |-> (live_en == '0));

endmodule

// File: tb/xpt_cfg_top_tb.sv
module xpt_cfg_top_tb_top;
  localparam int NO = 17;
  localparam int NI = 33;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, we_n, re_n, upd_n;
  logic [4:0] addr;
  logic [6:0] din;
  wire  [6:0] dout;
  wire        dout_oe;
  wire  [NO*6-1:0] live_sel;
  wire  [NO-1:0]   live_en;
  wire        sel_err;

  xpt_cfg_top dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .re_n(re_n),
    .upd_n(upd_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .live_sel(live_sel), .live_en(live_en), .sel_err(sel_err)
  );

  int m_stage[NO];
  int m_live[NO];
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NO; i++) begin
      m_stage[i] = 0;
      m_live[i]  = 0;
    end
  endtask

  task automatic step(input bit r, input bit c, input bit w, input bit rd,
                      input bit u, input int a, input int d, input string tag);
    int exp_dout, exp_oe, exp_err;
    bit wr;
    @(negedge clk);
    rst_n = r; cs_n = c; we_n = w; re_n = rd; upd_n = u;
    addr = 5'(a); din = 7'(d);
    if (!r) model_reset();
    #2;
    exp_oe   = (!c && !rd) ? 1 : 0;
    exp_dout = (exp_oe == 1 && a < NO) ? m_live[a] : 0;
    exp_err  = (!c && !w && a <= NO && (d % 64) > 32) ? 1 : 0;
    chk({tag, " dout_oe"}, int'(dout_oe), exp_oe);
    chk({tag, " dout"}, int'(dout), exp_dout);
    chk({tag, " sel_err"}, int'(sel_err), exp_err);
    @(posedge clk);
    if (r && !c) begin
      wr = !w && a <= NO;
      for (int i = 0; i < NO; i++) begin
        bit hit;
        hit = wr && (a == NO || a == i);
        if (!u) m_live[i] = hit ? d : m_stage[i];
        if (hit) m_stage[i] = d;
      end
    end
    #1;
    for (int i = 0; i < NO; i++) begin
      chk({tag, " R12 live_sel"}, int'(live_sel[i*6 +: 6]), m_live[i] % 64);
      chk({tag, " R12 live_en"}, int'(live_en[i]), m_live[i] / 64);
    end
  endtask

  // shorthand: c w rd u
  task automatic idle(input string tag);
    step(1, 0, 1, 1, 1, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; cs_n = 1; we_n = 1; re_n = 1; upd_n = 1; addr = '0; din = '0;
    model_reset();
    // R1: reset state, then update after reset
    step(0, 1, 1, 1, 1, 0, 0, "R1");
    step(0, 1, 1, 1, 1, 0, 0, "R1");
    step(1, 0, 1, 1, 0, 0, 0, "R1 upd");
    // R3: staged write, live unchanged, readback shows old live
    step(1, 0, 0, 1, 1, 0, 7'h45, "R3");
    step(1, 0, 0, 1, 1, 16, 7'h60, "R3");
    step(1, 0, 1, 0, 1, 0, 0, "R3 rd");
    // R5: global update moves both
    step(1, 0, 1, 1, 0, 0, 0, "R5");
    // R4: readback of live entries
    step(1, 0, 1, 0, 1, 0, 0, "R4");
    step(1, 0, 1, 0, 1, 16, 0, "R4");
    step(1, 0, 1, 0, 1, 5, 0, "R4");
    // R2: chip select high blocks everything
    step(1, 1, 0, 0, 0, 0, 7'h11, "R2");
    step(1, 1, 0, 0, 0, 17, 7'h22, "R2");
    // R6: staged write on 2, then write-through on 3
    step(1, 0, 0, 1, 1, 2, 7'h4C, "R6 pre");
    step(1, 0, 0, 1, 0, 3, 7'h5F, "R6");
    step(1, 0, 1, 0, 1, 3, 0, "R6 rd");
    step(1, 0, 1, 0, 1, 2, 0, "R6 rd");
    // R7: broadcast staged, then update
    step(1, 0, 0, 1, 1, 17, 7'h4A, "R7");
    step(1, 0, 1, 1, 0, 0, 0, "R7 upd");
    step(1, 0, 1, 0, 1, 9, 0, "R7 rd");
    // R8: readback of broadcast and reserved addresses
    step(1, 0, 1, 0, 1, 17, 0, "R8");
    step(1, 0, 1, 0, 1, 25, 0, "R8");
    step(1, 0, 1, 0, 1, 31, 0, "R8");
    // R9: reserved address writes are dropped
    step(1, 0, 0, 1, 1, 20, 7'h01, "R9");
    step(1, 0, 0, 1, 0, 31, 7'h02, "R9");
    step(1, 0, 1, 1, 0, 0, 0, "R9 upd");
    // R10: out-of-range input number, stored and flagged
    step(1, 0, 0, 1, 0, 4, 7'h68, "R10");
    step(1, 0, 0, 1, 1, 17, 7'h3F, "R10");
    step(1, 0, 0, 1, 1, 22, 7'h3F, "R10 rsvd");
    step(1, 0, 1, 0, 1, 4, 0, "R10 rd");
    // R11: read during write and during write-through
    step(1, 0, 0, 0, 1, 6, 7'h41, "R11");
    step(1, 0, 0, 0, 0, 6, 7'h42, "R11");
    step(1, 0, 1, 0, 1, 6, 0, "R11 rd");
    // R1: reset mid-run clears everything
    step(0, 0, 1, 1, 1, 0, 0, "R1 mid");
    step(1, 0, 1, 1, 0, 0, 0, "R1 mid upd");
    // R12: mixed traffic
    for (int k = 0; k < 400; k++) begin
      int a, d;
      bit c, w, rd, u;
      a  = $urandom_range(0, 31);
      d  = $urandom_range(0, 127);
      c  = ($urandom_range(0, 7) == 0);
      w  = $urandom_range(0, 1);
      rd = $urandom_range(0, 1);
      u  = ($urandom_range(0, 3) != 0);
      if (a > 18 && $urandom_range(0, 1) == 1) a = a % NO;
      step(1, c, w, rd, u, a, d, "R12");
    end
    idle("R12");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule